// File: doc/BRIEF.md
# Home Node Sharer Directory

This block sits at the home node of a group of cache lines in a distributed shared-memory machine. For every line it owns, it keeps one presence bit per node of the system and a small line state. The state is uncached, shared or exclusive. Remote nodes send it read requests and write (ownership) requests. The directory decides whether a request can be granted at once. If it cannot, the directory first sends one fan-out message to every node that must give up its copy, and waits for their acknowledgements before it grants.

Reads can be shared by any number of nodes. A write needs sole ownership, so every other copy is invalidated first. A read to a line that another node holds exclusively recalls the line from that owner, and the line then becomes shared by both nodes. One message-bearing transaction is tracked at a time. While it waits, requests to its line are held back. Requests to other lines that need no messages still go through. The node count sets the vector width, so it is the scaling limit of the scheme.

Top module: `home_dir`

## Requirements
- R1: After reset every line is uncached with an empty vector: the first request to any line is accepted and granted with no message, and `reqReady` is 1 while nothing is pending.
- R2: A read to an uncached or shared line is granted in the cycle after acceptance with `grantExcl`=0 and no message, and the reader's bit is added to the line's vector.
- R3: A write to a line that other nodes hold causes one message, in the cycle after acceptance, with `purgeRecall`=0, `purgeAddr` equal to the line, and `purgeMask` set exactly for the other holders (bit n = node n). The writer's own bit is never set in it.
- R4: A write that caused a message is granted with `grantExcl`=1 in the cycle after the cycle in which the last outstanding acknowledgement arrives on `ackVec` (bit n = ack from node n), and not before. Afterwards the writer is the sole holder and the line is exclusive.
- R5: A read to a line held exclusively by another node causes one message with `purgeRecall`=1 whose mask is the owner alone. After the owner's acknowledgement the reader is granted with `grantExcl`=0, and owner and reader both hold the line as sharers.
- R6: A read or write from the node that already holds the line exclusively is granted in the cycle after acceptance with `grantExcl`=1 and no message.
- R7: While a transaction waits for acknowledgements, `reqReady` is 0 for any request to that transaction's line, until its grant has been issued.
- R8: While a transaction waits, a request to another line that needs no message is accepted and granted normally. A request to another line that would need a message is held with `reqReady`=0.
- R9: A write to a line whose vector holds no node other than the writer is granted in the cycle after acceptance with `grantExcl`=1 and no message.
- R10: Acknowledgement bits from nodes that are not awaited are ignored: they neither complete the transaction nor cause a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The offered request is accepted at this edge |
| reqNode | input | 3 | Requesting node id |
| reqAddr | input | 6 | Line index at this home |
| reqWrite | input | 1 | 1 = write/ownership, 0 = read |
| purgeValid | output | 1 | Fan-out message valid for one cycle |
| purgeMask | output | 8 | Nodes addressed by the message |
| purgeAddr | output | 6 | Line the message concerns |
| purgeRecall | output | 1 | 1 = recall from exclusive owner, 0 = invalidate |
| ackVec | input | 8 | Acknowledgement pulses, one bit per node |
| grantValid | output | 1 | Grant valid for one cycle |
| grantNode | output | 3 | Node being granted |
| grantAddr | output | 6 | Granted line |
| grantExcl | output | 1 | 1 = line now exclusive to grantNode |

## Verification
A corrupted presence vector shows up in the mask of the next message for that line. That message comes one cycle after the next conflicting request is accepted. A stale bit adds a node to the mask, and a lost bit leaves out a node that still holds a copy. A wrong line state shows up either as a missing message or as a grant that comes too early, with the wrong exclusive flag. A wrong pending set shows up as a grant before the last acknowledgement, or as no grant at all. The bench therefore follows each line's holders through the sequence and checks every message mask and the exact cycle of every grant.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;
  parameter int NODES  = 8;
  parameter int LINES  = 64;
  localparam int NODE_W = $clog2(NODES);
  localparam int ADDR_W = $clog2(LINES);

  typedef enum logic [1:0] {
    LINE_UNC = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } line_state_e;

  typedef struct packed {
    logic [NODES-1:0] vec;
    line_state_e      st;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              dirWr;
    logic [ADDR_W-1:0] dirAddr;
    logic [NODES-1:0]  dirVec;
    line_state_e       dirState;
    logic              grantEn;
    logic [NODE_W-1:0] grantNode;
    logic [ADDR_W-1:0] grantAddr;
    logic              grantExcl;
    logic              msgEn;
    logic [NODES-1:0]  msgMask;
    logic [ADDR_W-1:0] msgAddr;
    logic              msgRecall;
  } cmd_t;
endpackage

// File: rtl/home_dir_datapath.sv
module home_dir_datapath
  import home_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] slotAddr,
  output entry_t            reqEntry,
  output entry_t            slotEntry,
  output logic              purgeValid,
  output logic [NODES-1:0]  purgeMask,
  output logic [ADDR_W-1:0] purgeAddr,
  output logic              purgeRecall,
  output logic              grantValid,
  output logic [NODE_W-1:0] grantNode,
  output logic [ADDR_W-1:0] grantAddr,
  output logic              grantExcl
);
  entry_t dirMem [LINES];

  assign reqEntry  = dirMem[reqAddr];
  assign slotEntry = dirMem[slotAddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        dirMem[i] <= '{vec: '0, st: LINE_UNC};
      end
    end else if (cmd.dirWr) begin
      dirMem[cmd.dirAddr] <= '{vec: cmd.dirVec, st: cmd.dirState};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      purgeValid  <= 1'b0;
      purgeMask   <= '0;
      purgeAddr   <= '0;
      purgeRecall <= 1'b0;
      grantValid  <= 1'b0;
      grantNode   <= '0;
      grantAddr   <= '0;
      grantExcl   <= 1'b0;
    end else begin
      purgeValid  <= cmd.msgEn;
      purgeMask   <= cmd.msgEn ? cmd.msgMask : '0;
      purgeAddr   <= cmd.msgAddr;
      purgeRecall <= cmd.msgRecall;
      grantValid  <= cmd.grantEn;
      grantNode   <= cmd.grantNode;
      grantAddr   <= cmd.grantAddr;
      grantExcl   <= cmd.grantExcl;
    end
  end

  // an exclusive line always has exactly one holder (R4, R6, R9)
  assert_excl_single_owner_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd.dirWr && cmd.dirState == LINE_EXC) |-> ($countones(cmd.dirVec) == 1));

  // a shared line always has at least one holder (R2, R5)
  assert_shared_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd.dirWr && cmd.dirState == LINE_SHR) |-> (cmd.dirVec != '0));

  // a message always addresses someone (R3)
  assert_purge_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    purgeValid |-> (purgeMask != '0));

  // a recall targets only the single owner (R5)
  assert_recall_one_owner_R5: assert property (@(posedge clk) disable iff (rst)
    (purgeValid && purgeRecall) |-> ($countones(purgeMask) == 1));
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import home_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              reqReady,
  input  logic [NODES-1:0]  ackVec,
  input  entry_t            reqEntry,
  input  entry_t            slotEntry,
  output logic [ADDR_W-1:0] slotAddr,
  output cmd_t              cmd
);
  logic              busyQ;
  logic [NODES-1:0]  pendQ;
  logic [NODE_W-1:0] slotNodeQ;
  logic [ADDR_W-1:0] slotAddrQ;
  logic              slotWriteQ;

  logic [NODES-1:0]  reqBit, others, slotBit, stillOut, immVec;
  line_state_e       immSt;
  logic              immExcl, needMsg, finishing, accept;

  assign slotAddr = slotAddrQ;

  always_comb begin
    reqBit  = NODES'(1) << reqNode;
    slotBit = NODES'(1) << slotNodeQ;
    others  = reqEntry.vec & ~reqBit;
    if (reqWrite) begin
      needMsg = |others;
      immVec  = reqBit;
      immSt   = LINE_EXC;
      immExcl = 1'b1;
    end else if (reqEntry.st == LINE_EXC) begin
      needMsg = |others;
      immVec  = reqEntry.vec;
      immSt   = LINE_EXC;
      immExcl = 1'b1;
    end else begin
      needMsg = 1'b0;
      immVec  = reqEntry.vec | reqBit;
      immSt   = LINE_SHR;
      immExcl = 1'b0;
    end
    stillOut  = pendQ & ~ackVec;
    finishing = busyQ && (stillOut == '0);
    reqReady  = !busyQ || (!finishing && !needMsg && (reqAddr != slotAddrQ));
    accept    = reqValid && reqReady;
  end

  always_comb begin
    cmd = '0;
    if (finishing) begin
      cmd.dirWr     = 1'b1;
      cmd.dirAddr   = slotAddrQ;
      cmd.dirVec    = slotWriteQ ? slotBit : (slotEntry.vec | slotBit);
      cmd.dirState  = slotWriteQ ? LINE_EXC : LINE_SHR;
      cmd.grantEn   = 1'b1;
      cmd.grantNode = slotNodeQ;
      cmd.grantAddr = slotAddrQ;
      cmd.grantExcl = slotWriteQ;
    end else if (accept && !needMsg) begin
      cmd.dirWr     = 1'b1;
      cmd.dirAddr   = reqAddr;
      cmd.dirVec    = immVec;
      cmd.dirState  = immSt;
      cmd.grantEn   = 1'b1;
      cmd.grantNode = reqNode;
      cmd.grantAddr = reqAddr;
      cmd.grantExcl = immExcl;
    end else if (accept) begin
      cmd.msgEn     = 1'b1;
      cmd.msgMask   = others;
      cmd.msgAddr   = reqAddr;
      cmd.msgRecall = !reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ      <= 1'b0;
      pendQ      <= '0;
      slotNodeQ  <= '0;
      slotAddrQ  <= '0;
      slotWriteQ <= 1'b0;
    end else if (accept && needMsg) begin
      busyQ      <= 1'b1;
      pendQ      <= others;
      slotNodeQ  <= reqNode;
      slotAddrQ  <= reqAddr;
      slotWriteQ <= reqWrite;
    end else if (finishing) begin
      busyQ <= 1'b0;
      pendQ <= '0;
    end else if (busyQ) begin
      pendQ <= stillOut;
    end
  end

  // the awaited set only loses members while waiting (R10)
  assert_pending_only_shrinks_R10: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !finishing) |=> ((pendQ & ~$past(pendQ)) == '0));

  // a message never targets the node that caused it (R3)
  assert_purge_skips_requester_R3: assert property (@(posedge clk) disable iff (rst)
    cmd.msgEn |-> ((cmd.msgMask & reqBit) == '0));

  // the waiting line is locked until its grant (R7)
  assert_locked_line_R7: assert property (@(posedge clk) disable iff (rst)
    (busyQ && reqValid && reqAddr == slotAddrQ) |-> !accept);
endmodule

// File: rtl/home_dir.sv
module home_dir
  import home_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              purgeValid,
  output logic [NODES-1:0]  purgeMask,
  output logic [ADDR_W-1:0] purgeAddr,
  output logic              purgeRecall,
  input  logic [NODES-1:0]  ackVec,
  output logic              grantValid,
  output logic [NODE_W-1:0] grantNode,
  output logic [ADDR_W-1:0] grantAddr,
  output logic              grantExcl
);
  cmd_t              cmd;
  entry_t            reqEntry, slotEntry;
  logic [ADDR_W-1:0] slotAddr;

  home_dir_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqNode(reqNode),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqReady(reqReady),
    .ackVec(ackVec), .reqEntry(reqEntry), .slotEntry(slotEntry),
    .slotAddr(slotAddr), .cmd(cmd)
  );

  home_dir_datapath u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .reqAddr(reqAddr), .slotAddr(slotAddr),
    .reqEntry(reqEntry), .slotEntry(slotEntry),
    .purgeValid(purgeValid), .purgeMask(purgeMask), .purgeAddr(purgeAddr),
    .purgeRecall(purgeRecall), .grantValid(grantValid), .grantNode(grantNode),
    .grantAddr(grantAddr), .grantExcl(grantExcl)
  );
endmodule

// File: tb/tb_home_dir.sv
module tb_home_dir;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [2:0] reqNode = '0;
  logic [5:0] reqAddr = '0;
  logic       reqWrite = 1'b0;
  logic       purgeValid, purgeRecall, grantValid, grantExcl;
  logic [7:0] purgeMask;
  logic [5:0] purgeAddr, grantAddr;
  logic [2:0] grantNode;
  logic [7:0] ackVec = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [9:0]  expGrant[$];
  string       grantTag[$];
  logic [14:0] expPurge[$];
  string       purgeTag[$];

  always #10 clk = ~clk;  // 50 MHz

  home_dir dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqNode(reqNode), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .purgeValid(purgeValid), .purgeMask(purgeMask), .purgeAddr(purgeAddr),
    .purgeRecall(purgeRecall), .ackVec(ackVec), .grantValid(grantValid),
    .grantNode(grantNode), .grantAddr(grantAddr), .grantExcl(grantExcl)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares outputs against the scoreboard queues
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (grantValid) begin
        logic [9:0] got;
        got = {grantNode, grantAddr, grantExcl};
        if (expGrant.size() == 0)
          check(0, "R4", "unexpected grant", int'(got), 0);
        else begin
          logic [9:0] e;
          string t;
          e = expGrant.pop_front();
          t = grantTag.pop_front();
          check(got == e, t, "grant {node,addr,excl}", int'(got), int'(e));
        end
      end
      if (purgeValid) begin
        logic [14:0] got;
        got = {purgeMask, purgeAddr, purgeRecall};
        if (expPurge.size() == 0)
          check(0, "R3", "unexpected message", int'(got), 0);
        else begin
          logic [14:0] e;
          string t;
          e = expPurge.pop_front();
          t = purgeTag.pop_front();
          check(got == e, t, "message {mask,addr,recall}", int'(got), int'(e));
        end
      end
    end
  end

  task automatic expG(input int node, input int addr, input bit ex, input string tag);
    expGrant.push_back({3'(node), 6'(addr), ex});
    grantTag.push_back(tag);
  endtask

  task automatic expP(input int mask, input int addr, input bit rc, input string tag);
    expPurge.push_back({8'(mask), 6'(addr), rc});
    purgeTag.push_back(tag);
  endtask

  task automatic sendReq(input int node, input int addr, input bit wr);
    @(negedge clk);
    reqValid = 1'b1; reqNode = 3'(node); reqAddr = 6'(addr); reqWrite = wr;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic probeHeld(input int node, input int addr, input bit wr, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqNode = 3'(node); reqAddr = 6'(addr); reqWrite = wr;
    #1;
    check(reqReady == 1'b0, tag, "reqReady while held", int'(reqReady), 0);
    reqValid = 1'b0;
  endtask

  task automatic sendAck(input int mask);
    @(negedge clk);
    ackVec = 8'(mask);
    @(negedge clk);
    ackVec = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(grantValid == 0, "R1", "grantValid after reset", int'(grantValid), 0);
    check(purgeValid == 0, "R1", "purgeValid after reset", int'(purgeValid), 0);
    check(reqReady == 1, "R1", "reqReady after reset", int'(reqReady), 1);

    // R1/R2: readers accumulate on line 5
    expG(1, 5, 0, "R1"); sendReq(1, 5, 0);
    expG(2, 5, 0, "R2"); sendReq(2, 5, 0);
    expG(3, 5, 0, "R2"); sendReq(3, 5, 0);
    idle(2);

    // R3: node 2 writes; nodes 1 and 3 must be purged
    expP(8'b0000_1010, 5, 0, "R3"); sendReq(2, 5, 1);
    idle(2);
    // R10: stray ack from node 6 must not complete
    sendAck(8'b0100_0000);
    idle(2);
    // R7: same line held
    probeHeld(4, 5, 0, "R7");
    // R8: other line with no message passes
    expG(4, 9, 0, "R8"); sendReq(4, 9, 0);
    idle(1);
    // R8: other line needing a message is held
    probeHeld(5, 9, 1, "R8");
    // R4: partial ack, still no grant
    sendAck(8'b0000_0010);
    idle(2);
    probeHeld(4, 5, 0, "R7");
    expG(2, 5, 1, "R4"); sendAck(8'b0000_1000);
    idle(2);

    // R6: owner requests again
    expG(2, 5, 1, "R6"); sendReq(2, 5, 1);
    expG(2, 5, 1, "R6"); sendReq(2, 5, 0);
    idle(2);

    // R5: node 7 reads the exclusive line
    expP(8'b0000_0100, 5, 1, "R5"); sendReq(7, 5, 0);
    idle(2);
    expG(7, 5, 0, "R5"); sendAck(8'b0000_0100);
    idle(2);
    // R5/R4: both sharers are purged by a third writer
    expP(8'b1000_0100, 5, 0, "R5"); sendReq(0, 5, 1);
    idle(1);
    sendAck(8'b0000_0100);
    idle(1);
    expG(0, 5, 1, "R4"); sendAck(8'b1000_0000);
    idle(2);

    // R9: writes with no other holder
    expG(3, 20, 1, "R9"); sendReq(3, 20, 1);
    expG(4, 30, 0, "R2"); sendReq(4, 30, 0);
    expG(4, 30, 1, "R9"); sendReq(4, 30, 1);
    idle(2);

    // boundary: last line, last node
    expG(7, 63, 0, "R2"); sendReq(7, 63, 0);
    expP(8'b1000_0000, 63, 0, "R3"); sendReq(0, 63, 1);
    idle(1);
    expG(0, 63, 1, "R4"); sendAck(8'b1000_0000);
    idle(4);

    check(expGrant.size() == 0, "R4", "grants still expected", expGrant.size(), 0);
    check(expPurge.size() == 0, "R3", "messages still expected", expPurge.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule